// File: doc/BRIEF.md
# I2C Slave Receive Engine with Clock Stretching

This block is the receive side of an I2C target inside a microcontroller peripheral. It oversamples SCL and SDA with the fast system clock and finds START, repeated START and STOP conditions. It then takes in a 7-bit address and compares it with a programmed own address. A general-call address of zero can also be accepted. After a match it receives data bytes, MSB first. After each event it holds SCL low, so software has time to react. Any write to the status location releases the line.

Software drives the block through a plain write-strobe bus. The mode location holds the enable, the interrupt enable and the ACK policy bit. Other locations hold the own address with its general-call bit, and the SDA hold count. The received byte and three event flags (select, byte done, stop) are brought out as read-only outputs, along with an interrupt line. The block never drives the bus high. `scl_oe` and `sda_oe` request an open-drain pull-down.

Top module: `i2c_slave_rx`

## Requirements
- R1: Both bit 0 (enable) and bit 1 (interrupt enable) of the mode location (address 0) must be set for the block to work. Otherwise it pulls neither line low and sets no flag, and `irq` stays low.
- R2: After a START, the first byte is shifted in MSB first. It is a match when its bits 7:1 equal bits 7:1 of the own-address location (address 1), its bit 0 (read/write) is 0, and ACK-enable (mode bit 2) is set. On a match the block sets `sel_flag`, holds SCL low and pulls SDA low for the ninth clock.
- R3: An address byte of 0x00 matches only while the general-call bit (own-address location bit 0) is set.
- R4: On an address mismatch, a read/write bit of 1, or a clear ACK-enable, the block sets no flag and drives no line. It ignores the rest of the transfer until the next START.
- R5: A write to the status location (address 3) with any data clears all three flags and releases a held SCL.
- R6: In a selected transfer, each data byte is presented on `rx_data` MSB first after its eighth bit. At that point `byte_flag` is set and SCL is held low.
- R7: The ACK-enable value at the moment of the release decides the ninth bit. When set, SDA is pulled low and further bytes are received. When clear, SDA stays high, and later bytes leave `rx_data` and the flags unchanged until a STOP or START.
- R8: A repeated START at any point, including in the middle of a byte, returns the block to the address phase.
- R9: A STOP after a matched address sets `stop_flag`. A STOP without a match sets nothing. `irq` is high whenever any flag is set.
- R10: With hold count H in the hold location (address 2), the end of an ACK pull-down occurs on the (H+4)th rising clock edge after the SCL input falls. The SCL stretch is released only once SDA has reached its new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register location: 0 mode, 1 own address, 2 hold, 3 status |
| reg_wdata | input | 8 | Register write data |
| rx_data | output | 8 | Last received data byte |
| sel_flag | output | 1 | Address matched, SCL held |
| byte_flag | output | 1 | Data byte received, SCL held |
| stop_flag | output | 1 | STOP seen after a match |
| irq | output | 1 | Any flag set |

## Verification
The hardest case to reach is a repeated START that arrives in the middle of a byte, after a session has already been selected. Only a master that aborts a byte partway can produce it. The bench's bus model clocks out three bits and then issues the repeated START and a fresh address. Random transfers mix own, general-call, read and foreign addresses with random per-byte ACK choices and hold counts. The bench also times each ACK release edge against the SCL fall in clock cycles.

// File: rtl/i2c_rx_pkg.sv
// Shared types and register locations for the I2C slave receive engine.
package i2c_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // shifting in address byte
        ST_AHOLD,  // address matched, SCL held
        ST_DATA,   // shifting in data byte
        ST_DHOLD,  // data byte done, SCL held
        ST_REL,    // SDA settling before SCL release
        ST_ACK,    // ninth clock with SDA pulled low
        ST_NACK    // not acknowledging, waiting for START or STOP
    } rx_state_e;

    localparam logic [1:0] LOC_MODE   = 2'd0;
    localparam logic [1:0] LOC_OWN    = 2'd1;
    localparam logic [1:0] LOC_HOLD   = 2'd2;
    localparam logic [1:0] LOC_STATUS = 2'd3;
endpackage

// File: rtl/i2c_rx_linesync.sv
// Synchronises SCL and SDA into the system clock domain and flags edges
// and bus conditions. Assumes the bus is idle high out of reset.
module i2c_rx_linesync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe, sda_pipe;
    logic         scl_d, sda_d;
    logic         scl_s;

    // Shift both lines through the synchroniser chain and keep one old copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_d    <= scl_pipe[TOP];
            sda_d    <= sda_pipe[TOP];
        end
    end

    assign scl_s = scl_pipe[TOP];
    assign sda_s = sda_pipe[TOP];

    // Edge and condition decode on the synchronised levels.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_rx_sdahold.sv
// Delays each change of the SDA pull-down request by a programmable count.
// With count 0 the output follows the request one clock later.
module i2c_rx_sdahold #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [HOLD_W-1:0] hold,
    output logic              drv
);
    logic [HOLD_W-1:0] cnt;

    // Count while request and output differ, then copy the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv <= 1'b0;
            cnt <= '0;
        end else if (req == drv) begin
            cnt <= '0;
        end else if (cnt == hold) begin
            drv <= req;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_rx_fsm.sv
// Receive sequencer: address compare, byte shifting, stretching and flags.
// Assumes edge/condition pulses last one clock and SCL is wired-AND.
module i2c_rx_fsm
    import i2c_rx_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 ack_en,
    input  logic                 gc_en,
    input  logic [BYTE_BITS-2:0] own_addr,
    input  logic                 clr,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 sda_drv,
    output logic                 scl_hold,
    output logic                 sda_req,
    output logic [BYTE_BITS-1:0] rx_data,
    output logic                 sel_flag,
    output logic                 byte_flag,
    output logic                 stop_flag
);
    localparam int                CNT_W    = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_BITS);

    rx_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 addr_hit;
    logic                 selected;

    // Address decision on the completed first byte.
    always_comb begin
        addr_hit = ack_en && !shreg[0] &&
                   ((shreg[BYTE_BITS-1:1] == own_addr) ||
                    (gc_en && (shreg[BYTE_BITS-1:1] == '0)));
        selected = (state != ST_IDLE) && (state != ST_ADDR);
    end

    // Sequencer state, shift register, flags and line requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            rx_data   <= '0;
            sel_flag  <= 1'b0;
            byte_flag <= 1'b0;
            stop_flag <= 1'b0;
            scl_hold  <= 1'b0;
            sda_req   <= 1'b0;
        end else if (!active) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sel_flag  <= 1'b0;
            byte_flag <= 1'b0;
            stop_flag <= 1'b0;
            scl_hold  <= 1'b0;
            sda_req   <= 1'b0;
        end else begin
            if (clr) begin
                sel_flag  <= 1'b0;
                byte_flag <= 1'b0;
                stop_flag <= 1'b0;
            end
            if (start_det) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                scl_hold <= 1'b0;
                sda_req  <= 1'b0;
            end else if (stop_det) begin
                if (selected) stop_flag <= 1'b1;
                state    <= ST_IDLE;
                scl_hold <= 1'b0;
                sda_req  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_BITS-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            if (state == ST_DATA) begin
                                rx_data   <= shreg;
                                byte_flag <= 1'b1;
                                scl_hold  <= 1'b1;
                                state     <= ST_DHOLD;
                            end else if (addr_hit) begin
                                sel_flag <= 1'b1;
                                scl_hold <= 1'b1;
                                sda_req  <= 1'b1;
                                state    <= ST_AHOLD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AHOLD: if (clr) state <= ST_REL;
                    ST_DHOLD: begin
                        if (clr) begin
                            sda_req <= ack_en;
                            state   <= ST_REL;
                        end
                    end
                    ST_REL: begin
                        if (sda_drv == sda_req) begin
                            scl_hold <= 1'b0;
                            state    <= sda_req ? ST_ACK : ST_NACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_req <= 1'b0;
                            cnt     <= '0;
                            state   <= ST_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_slave_rx.sv
// I2C slave receive engine top: register file, line sync, SDA hold delay
// and the receive sequencer. Outputs are open-drain pull-down requests.
module i2c_slave_rx
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_W      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] rx_data,
    output logic       sel_flag,
    output logic       byte_flag,
    output logic       stop_flag,
    output logic       irq
);
    localparam int BYTE_BITS = 8;

    logic                 en_q, ien_q, ack_en_q, gc_en_q;
    logic [BYTE_BITS-2:0] own_q;
    logic [HOLD_W-1:0]    hold_q;
    logic                 active, clr;
    logic                 sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                 scl_hold, sda_req, sda_drv;

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            ien_q    <= 1'b0;
            ack_en_q <= 1'b0;
            gc_en_q  <= 1'b0;
            own_q    <= '0;
            hold_q   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                LOC_MODE: begin
                    en_q     <= reg_wdata[0];
                    ien_q    <= reg_wdata[1];
                    ack_en_q <= reg_wdata[2];
                end
                LOC_OWN: begin
                    gc_en_q <= reg_wdata[0];
                    own_q   <= reg_wdata[BYTE_BITS-1:1];
                end
                LOC_HOLD: hold_q <= HOLD_W'(reg_wdata);
                default: ;
            endcase
        end
    end

    assign active = en_q & ien_q;
    assign clr    = reg_wr && (reg_addr == LOC_STATUS);

    i2c_rx_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rx_sdahold #(.HOLD_W(HOLD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .req(sda_req), .hold(hold_q), .drv(sda_drv)
    );

    i2c_rx_fsm #(.BYTE_BITS(BYTE_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .ack_en(ack_en_q),
        .gc_en(gc_en_q), .own_addr(own_q), .clr(clr), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_drv(sda_drv), .scl_hold(scl_hold),
        .sda_req(sda_req), .rx_data(rx_data), .sel_flag(sel_flag),
        .byte_flag(byte_flag), .stop_flag(stop_flag)
    );

    assign scl_oe = scl_hold;
    assign sda_oe = sda_drv;
    assign irq    = sel_flag | byte_flag | stop_flag;
endmodule

// File: rtl/i2c_slave_rx_chk.sv
// Protocol checker for the I2C slave receive engine, bound to the top.
module i2c_slave_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       active,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic       scl_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       sel_flag,
    input logic       byte_flag,
    input logic       irq
);
    // Disabled block is silent on SCL and interrupt.
    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!scl_oe && !irq));

    // A status write during a stretch clears the event flags.
    assert_clear_on_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3 && scl_oe) |=> (!sel_flag && !byte_flag));

    // A stretch always starts together with a select or byte event.
    assert_stretch_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> (sel_flag || byte_flag));

    // The SDA pull-down only changes while SCL is low.
    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !$stable(sda_oe)) |-> !scl_i);
endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sel_flag(sel_flag), .byte_flag(byte_flag), .irq(irq)
);

// File: tb/i2c_slave_rx_bench.sv
// Self-checking bench: a bus master model with wired-AND lines, directed
// corner cases and seeded random transfers.
module i2c_slave_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T          = 12;   // clocks per bus phase
    localparam logic [1:0] A_MODE = 2'd0, A_OWN = 2'd1, A_HOLD = 2'd2, A_STAT = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_i, sda_i, scl_oe, sda_oe;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] rx_data;
    logic       sel_flag, byte_flag, stop_flag, irq;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] exp_rx = 8'h00;

    assign scl_i = scl_m & ~scl_oe;
    assign sda_i = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_slave_rx u_i2c_slave_rx (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rx_data(rx_data),
        .sel_flag(sel_flag), .byte_flag(byte_flag), .stop_flag(stop_flag),
        .irq(irq)
    );

    function automatic bit expect_hit(input logic [7:0] a, input logic [6:0] own,
                                      input bit gc, input bit ack);
        return ack && !a[0] && ((a[7:1] == own) || (gc && a[7:1] == 7'd0));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_scl_high();
        while (scl_i !== 1'b1) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_cyc(T);
        sda_m = 1'b0; wait_cyc(T);
        scl_m = 1'b0; wait_cyc(T);
    endtask

    task automatic bus_restart();
        sda_m = 1'b1; wait_cyc(T);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(T);
        sda_m = 1'b0; wait_cyc(T);
        scl_m = 1'b0; wait_cyc(T);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(T);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(T);
        sda_m = 1'b1; wait_cyc(T);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wait_cyc(T);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(T);
        scl_m = 1'b0; wait_cyc(T);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
    endtask

    // Ninth clock: sample ACK, then time the end of the pull-down (R10).
    task automatic ack_clock(input int hold, input bit exp_ack, input string req);
        int n;
        sda_m = 1'b1; wait_cyc(T);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(T/2);
        chk(req, sda_i, exp_ack ? 0 : 1);
        wait_cyc(T/2);
        scl_m = 1'b0;
        if (exp_ack) begin
            n = 0;
            do begin
                @(posedge clk); n++; @(negedge clk);
            end while (sda_oe && n < 64);
            chk("R10", n, hold + 4);
        end
        wait_cyc(T);
    endtask

    task automatic release_chk();
        wr(A_STAT, 8'($urandom));
        wait_cyc(T);
        chk("R5", scl_oe, 0);
        chk("R5", sel_flag | byte_flag, 0);
    endtask

    // One transfer: address, nb data bytes with per-byte ACK choice, STOP.
    task automatic run_txn(input logic [7:0] abyte, input logic [6:0] own, input bit gc,
                           input bit ack_addr, input int nb, input int hold,
                           input logic [2:0] acks);
        bit hit, live;
        string tag;
        logic [7:0] d;
        wr(A_MODE, {5'b0, ack_addr, 2'b11});
        wr(A_OWN, {own, gc});
        wr(A_HOLD, 8'(hold));
        hit = expect_hit(abyte, own, gc, ack_addr);
        tag = (abyte[7:1] == 7'd0) ? "R3" : (hit ? "R2" : "R4");
        bus_start();
        send_byte(abyte);
        chk(tag, sel_flag, hit);
        chk(tag, scl_oe, hit);
        if (hit) begin
            release_chk();
            ack_clock(hold, 1'b1, "R2");
        end else begin
            ack_clock(hold, 1'b0, "R4");
        end
        live = hit;
        for (int k = 0; k < nb; k++) begin
            d = 8'($urandom);
            send_byte(d);
            if (live) begin
                chk("R6", byte_flag, 1);
                chk("R6", scl_oe, 1);
                chk("R6", rx_data, d);
                exp_rx = d;
                wr(A_MODE, {5'b0, acks[k], 2'b11});
                release_chk();
                ack_clock(hold, acks[k], "R7");
                live = acks[k];
            end else begin
                chk("R7", byte_flag, 0);
                chk("R7", scl_oe, 0);
                chk("R7", rx_data, exp_rx);
                ack_clock(hold, 1'b0, "R7");
            end
        end
        bus_stop();
        chk("R9", stop_flag, hit);
        chk("R9", irq, hit);
        wr(A_STAT, 8'h00);
        wait_cyc(2);
        chk("R5", stop_flag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] a, d;
        logic [6:0] own;
        int pick;
        void'($urandom(32'h51C2));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        // Reset state
        chk("R1", scl_oe, 0);
        chk("R1", sda_oe, 0);
        chk("R1", irq, 0);
        chk("R1", rx_data, 0);

        // R1: interrupt enable clear keeps the block inert
        own = 7'h2A;
        wr(A_OWN, {own, 1'b0});
        wr(A_MODE, 8'b0000_0101);
        bus_start();
        send_byte({own, 1'b0});
        chk("R1", sel_flag, 0);
        chk("R1", scl_oe, 0);
        ack_clock(0, 1'b0, "R1");
        bus_stop();
        chk("R1", irq, 0);

        // R3: general call with and without the enable bit
        run_txn(8'h00, own, 1'b0, 1'b1, 1, 1, 3'b001);
        run_txn(8'h00, own, 1'b1, 1'b1, 2, 1, 3'b011);
        // R4: read bit set, ACK-enable clear, foreign address
        run_txn({own, 1'b1}, own, 1'b0, 1'b1, 1, 0, 3'b001);
        run_txn({own, 1'b0}, own, 1'b0, 1'b0, 1, 0, 3'b001);
        run_txn({7'h15, 1'b0}, own, 1'b1, 1'b1, 1, 0, 3'b001);
        // R10: hold extremes
        run_txn({own, 1'b0}, own, 1'b0, 1'b1, 2, 0, 3'b011);
        run_txn({own, 1'b0}, own, 1'b0, 1'b1, 2, 9, 3'b001);

        // R8: repeated START after an ACKed byte and in the middle of a byte
        wr(A_MODE, 8'b0000_0111);
        wr(A_HOLD, 8'd2);
        bus_start();
        send_byte({own, 1'b0});
        chk("R2", sel_flag, 1);
        release_chk();
        ack_clock(2, 1'b1, "R2");
        d = 8'hC3;
        send_byte(d);
        chk("R6", rx_data, d);
        release_chk();
        ack_clock(2, 1'b1, "R7");
        bus_restart();
        send_byte({own, 1'b0});
        chk("R8", sel_flag, 1);
        chk("R8", scl_oe, 1);
        release_chk();
        ack_clock(2, 1'b1, "R8");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_restart();
        send_byte({own, 1'b0});
        chk("R8", sel_flag, 1);
        chk("R8", byte_flag, 0);
        release_chk();
        ack_clock(2, 1'b1, "R8");
        d = 8'h5A;
        send_byte(d);
        chk("R8", rx_data, d);
        exp_rx = d;
        wr(A_MODE, 8'b0000_0011);
        release_chk();
        ack_clock(2, 1'b0, "R7");
        bus_stop();
        chk("R9", stop_flag, 1);
        wr(A_STAT, 8'hFF);
        wait_cyc(2);
        chk("R5", irq, 0);

        // Seeded random transfers
        for (int n = 0; n < 30; n++) begin
            own  = 7'($urandom_range(1, 127));
            pick = $urandom_range(0, 9);
            if (pick < 5)       a = {own, 1'b0};
            else if (pick < 7)  a = 8'h00;
            else if (pick == 7) a = {own, 1'b1};
            else                a = 8'($urandom);
            run_txn(a, own, 1'($urandom_range(0, 1)), ($urandom_range(0, 4) != 0),
                    $urandom_range(1, 3), $urandom_range(0, 6),
                    3'($urandom_range(0, 7)));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule